// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two independent opinions. The first is a single shared 2-bit saturating counter that every branch trains. The second is a small table of 2-bit saturating counters, one per table slot, selected by low bits of the branch address. A third 2-bit saturating counter, the chooser, decides which of the two opinions is reported. The predict side is purely combinational. It takes an address and returns a direction plus a flag that names the component that supplied it. The update side takes the address and the resolved direction of a finished branch and trains all three counters on the next clock edge. An internal event counter accumulates the number of resolved branches that the chosen component got wrong, so the block can be compared against a software model.

Every counter is a four-state machine. For direction counters the states are SNT (00), WNT (01), WT (10) and ST (11). For the chooser the same encodings mean strongly-local (00), weakly-local (01), weakly-global (10) and strongly-global (11). Each machine has three transitions: STEP_UP moves to the next higher state and saturates at 11, STEP_DOWN moves to the next lower state and saturates at 00, and HOLD keeps the state. The direction counters take STEP_UP on a taken outcome and STEP_DOWN on a not-taken outcome. The chooser takes STEP_DOWN when only the local component was right, STEP_UP when only the global component was right, and HOLD otherwise.

Top module: `tournament_bp`

## Requirements
- R1: A direction counter predicts taken when its state is WT (10) or ST (11) and not-taken when it is SNT (00) or WNT (01). A taken outcome moves it one state up and a not-taken outcome moves it one state down.
- R2: The global component is one counter trained by every update, whatever the address. It leaves reset in the state given by GLOBAL_RST, which defaults to 10.
- R3: The local component holds LOCAL_DEPTH counters. Each one leaves reset in LOCAL_RST, which defaults to 01. The slot is selected by address bits [ALIGN_BITS +: log2(LOCAL_DEPTH)], which are bits [5:2] by default.
- R4: The chooser leaves reset in CHOICE_RST, which defaults to 10. When the chooser MSB is 1, `pred_src_global_o` is 1 and the global prediction is reported. When the MSB is 0, `pred_src_global_o` is 0 and the local prediction is reported.
- R5: The chooser changes only on an update where the two components predicted different directions. It moves down when the local component matched the outcome and up when the global component matched it.
- R6: Every counter saturates: it stays at 11 on STEP_UP and at 00 on STEP_DOWN.
- R7: On every update, both the global counter and the addressed local counter are trained, regardless of which component was chosen.
- R8: The prediction reflects the state before any update applied in the same cycle. An update becomes visible to predictions from the next cycle onward, including a prediction for the same address.
- R9: `miss_count_o` resets to 0. It increases by exactly one for each update whose chosen prediction, taken from the state before that update, differs from the outcome. It holds when there is no update.
- R10: Address bits outside the index field have no effect. Two addresses with equal index bits share one local counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc_i | input | PC_W | Address of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_src_global_o | output | 1 | 1 = global component chosen, 0 = local component chosen |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |
| miss_count_o | output | MISS_W | Count of resolved branches the chosen component mispredicted |

## Verification
A prediction and an update can fall in the same cycle, and they can target the same local slot. The bench provokes this in a long sweep where the predicted address often equals the updated address, or aliases to it through the index bits. A reference model in the bench judges each cycle. The model checks the reported prediction against the counter values that held before the edge. It then checks that the update became visible in the following cycle. The same sweep also exercises an update whose chooser and direction counters all move on one edge, while the miss counter is checked against the pre-update chosen prediction.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        C_SNT = 2'b00,
        C_WNT = 2'b01,
        C_WT  = 2'b10,
        C_ST  = 2'b11
    } ctr_t;
endpackage

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr
    import bp_pkg::*;
#(
    parameter logic [1:0] RST = 2'b10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic up,
    output ctr_t state_o,
    output logic msb_o
);
    ctr_t cur, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ctr_t'(RST);
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (en) begin
            unique case (cur)
                C_SNT: nxt = up ? C_WNT : C_SNT;
                C_WNT: nxt = up ? C_WT  : C_SNT;
                C_WT:  nxt = up ? C_ST  : C_WNT;
                C_ST:  nxt = up ? C_ST  : C_WT;
                default: nxt = cur;
            endcase
        end
    end

    always_comb begin
        state_o = cur;
        msb_o   = (cur == C_WT) || (cur == C_ST);
    end

    a_r6_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up && cur == C_ST) |=> (cur == C_ST));
    a_r6_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !up && cur == C_SNT) |=> (cur == C_SNT));
    a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up && cur != C_ST) |=> (cur == ctr_t'($past(cur) + 2'd1)));
    a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !up && cur != C_SNT) |=> (cur == ctr_t'($past(cur) - 2'd1)));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cur));
endmodule

// File: rtl/bp_local_table.sv
module bp_local_table
    import bp_pkg::*;
#(
    parameter int         DEPTH = 16,
    parameter logic [1:0] RST   = 2'b01,
    localparam int        IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic             rd_a_taken,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic             rd_b_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    logic [DEPTH-1:0] msb;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        ctr_t st_unused;
        logic slot_en;
        assign slot_en = wr_en && (wr_idx == IDX_W'(g));
        bp_sat_ctr #(.RST(RST)) i_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (slot_en),
            .up      (wr_taken),
            .state_o (st_unused),
            .msb_o   (msb[g])
        );
    end

    always_comb begin
        rd_a_taken = msb[rd_a_idx];
        rd_b_taken = msb[rd_b_idx];
    end
endmodule

// File: rtl/bp_chooser.sv
module bp_chooser
    import bp_pkg::*;
#(
    parameter logic [1:0] RST = 2'b10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_valid,
    input  logic glob_guess,
    input  logic loc_guess,
    input  logic outcome,
    output logic use_global
);
    logic disagree;
    logic toward_global;
    ctr_t st;

    always_comb begin
        disagree      = upd_valid && (glob_guess != loc_guess);
        toward_global = (glob_guess == outcome);
    end

    bp_sat_ctr #(.RST(RST)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (disagree),
        .up      (toward_global),
        .state_o (st),
        .msb_o   (use_global)
    );

    a_r5_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid || glob_guess == loc_guess) |=> $stable(st));
    a_r5_local_right: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && loc_guess == outcome && glob_guess != outcome && st != C_SNT)
        |=> (st == ctr_t'($past(st) - 2'd1)));
    a_r5_global_right: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && glob_guess == outcome && loc_guess != outcome && st != C_ST)
        |=> (st == ctr_t'($past(st) + 2'd1)));
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
    import bp_pkg::*;
#(
    parameter int         PC_W        = 32,
    parameter int         ALIGN_BITS  = 2,
    parameter int         LOCAL_DEPTH = 16,
    parameter int         MISS_W      = 16,
    parameter logic [1:0] GLOBAL_RST  = 2'b10,
    parameter logic [1:0] LOCAL_RST   = 2'b01,
    parameter logic [1:0] CHOICE_RST  = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc_i,
    output logic              pred_taken_o,
    output logic              pred_src_global_o,
    input  logic              upd_valid_i,
    input  logic [PC_W-1:0]   upd_pc_i,
    input  logic              upd_taken_i,
    output logic [MISS_W-1:0] miss_count_o
);
    localparam int IDX_W = $clog2(LOCAL_DEPTH);

    logic [IDX_W-1:0] pred_idx, upd_idx;
    logic glob_taken, loc_pred_taken, loc_upd_taken, use_global, upd_choice;
    ctr_t glob_state;
    logic [MISS_W-1:0] miss_q;

    always_comb begin
        pred_idx = pred_pc_i[ALIGN_BITS +: IDX_W];
        upd_idx  = upd_pc_i[ALIGN_BITS +: IDX_W];
    end

    bp_sat_ctr #(.RST(GLOBAL_RST)) i_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (upd_valid_i),
        .up      (upd_taken_i),
        .state_o (glob_state),
        .msb_o   (glob_taken)
    );

    bp_local_table #(.DEPTH(LOCAL_DEPTH), .RST(LOCAL_RST)) i_local (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (pred_idx),
        .rd_a_taken (loc_pred_taken),
        .rd_b_idx   (upd_idx),
        .rd_b_taken (loc_upd_taken),
        .wr_en      (upd_valid_i),
        .wr_idx     (upd_idx),
        .wr_taken   (upd_taken_i)
    );

    bp_chooser #(.RST(CHOICE_RST)) i_choose (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_valid  (upd_valid_i),
        .glob_guess (glob_taken),
        .loc_guess  (loc_upd_taken),
        .outcome    (upd_taken_i),
        .use_global (use_global)
    );

    always_comb begin
        upd_choice        = use_global ? glob_taken : loc_upd_taken;
        pred_taken_o      = use_global ? glob_taken : loc_pred_taken;
        pred_src_global_o = use_global;
        miss_count_o      = miss_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                    miss_q <= '0;
        else if (upd_valid_i && upd_choice != upd_taken_i) miss_q <= miss_q + 1'b1;
    end

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |=> $stable(miss_count_o));
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i |=> (miss_count_o == $past(miss_count_o) ||
                         miss_count_o == $past(miss_count_o) + 1'b1));
    a_r2_global_trains: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && upd_taken_i && glob_state == C_WT) |=> (glob_state == C_ST));
endmodule

// File: tb/test_tournament_bp.sv
`timescale 1ns/1ps
module test_tournament_bp;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken, pred_src_global;
    logic        upd_valid = 0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 0;
    logic [15:0] miss_count;

    int n_vec = 0, n_bad = 0;

    logic [1:0]  m_glob, m_choice;
    logic [1:0]  m_loc [16];
    logic [15:0] m_miss;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    tournament_bp i_tournament_bp (
        .clk              (clk),
        .rst_n            (rst_n),
        .pred_pc_i        (pred_pc),
        .pred_taken_o     (pred_taken),
        .pred_src_global_o(pred_src_global),
        .upd_valid_i      (upd_valid),
        .upd_pc_i         (upd_pc),
        .upd_taken_i      (upd_taken),
        .miss_count_o     (miss_count)
    );

    function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
        if (up) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] ppc, input logic v, input logic [31:0] upc,
                        input logic t, input string tag);
        logic [3:0] pi, ui;
        logic g, l, ch;
        pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
        @(negedge clk);
        pi = ppc[5:2]; ui = upc[5:2];
        check(pred_taken, m_choice[1] ? m_glob[1] : m_loc[pi][1], {tag, " R1 R8 prediction"});
        check(pred_src_global, m_choice[1], {tag, " R4 source"});
        check(miss_count, m_miss, {tag, " R9 miss count"});
        if (v) begin
            g  = m_glob[1];
            l  = m_loc[ui][1];
            ch = m_choice[1] ? g : l;
            if (ch != t) m_miss++;
            if (g != l) m_choice = sat(m_choice, g == t);
            m_glob   = sat(m_glob, t);
            m_loc[ui] = sat(m_loc[ui], t);
        end
        @(posedge clk); #1;
    endtask

    function automatic logic [15:0] nxt_lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        #(5.0 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        m_glob = 2'b10; m_choice = 2'b10; m_miss = '0;
        for (int i = 0; i < 16; i++) m_loc[i] = 2'b01;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R2 R4 R9: reset state, global taken chosen, zero misses
        step(32'h0, 0, 32'h0, 0, "reset R2");
        // R3: local slot reset value visible once chooser flips to local (R5)
        step(32'h4, 1, 32'h4, 0, "R5 local right");
        step(32'h8, 1, 32'h8, 0, "R5 second step R3");
        step(32'h8, 0, 32'h0, 0, "R3 local read");
        // R6: saturate one slot high and low
        for (int i = 0; i < 5; i++) step(32'h10, 1, 32'h10, 1, "R6 up");
        for (int i = 0; i < 5; i++) step(32'h10, 1, 32'h10, 0, "R6 down");
        // R10: aliasing through high address bits
        step(32'hFFFF_FF14, 1, 32'h0000_0014, 1, "R10 alias");
        step(32'h1234_5614, 1, 32'hABCD_0014, 1, "R10 alias");
        step(32'h0000_0014, 0, 32'h0, 0, "R10 alias read");
        // R7 R8: same-cycle predict and update sweep
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, b;
            logic t;
            lfsr = nxt_lfsr(lfsr);
            b = {lfsr[15:8], lfsr, lfsr[7:0]};
            a = lfsr[0] ? b : {b[31:6], lfsr[9:6], b[1:0]};
            t = (i < 2000) ? b[2] ^ (lfsr[12:10] == 3'b000) : lfsr[11];
            step(a, lfsr[14] | lfsr[3], b, t, "R7 R8 sweep");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule